// File: doc/BRIEF.md
# Multi-format serial audio input port

This block takes stereo PCM from a three-wire serial audio link and turns it into parallel samples. The wires are a bit clock, a frame clock that tells left from right, and a data line. All three are sampled in a faster system clock domain. One deserializer handles four framing conventions: left-justified, I2S, right-justified and a DSP mode that uses a short sync pulse. It accepts 16-, 20- or 24-bit words. Samples are two's complement and arrive MSB first. Each frame is 64 bit clocks long, 32 slots per channel in the half-frame framings.

Each channel has its own 24-bit output register and a one-cycle valid strobe. Shorter words are placed at the top of the register and the low bits are filled with zeros. In right-justified mode the word sits at the end of its half-frame, so the port finds the MSB by counting back from the frame-clock edge by the selected word length. A per-channel silence flag rises after a programmable run of all-zero samples on that channel. The format and word-length inputs are static; they are changed only while the port is held in reset.

Top module: `sai_rx_port`

## Requirements
- R1: While reset is held and after it is released, before any bit-clock activity, both data outputs are zero and both valid strobes and both zero flags are low.
- R2: Format code 00 (left-justified): the frame clock is high for left and low for right, and the MSB is the bit sampled on the first bit-clock rise after the frame clock changes.
- R3: Format code 01 (I2S): the frame clock is low for left and high for right, and the MSB is sampled on the second bit-clock rise after the frame clock changes.
- R4: Format code 10 (right-justified): the frame clock is high for left, the LSB is the last bit before the frame clock changes, and that word is delivered once that change is seen.
- R5: Format code 11 (DSP): a frame clock that is high for one bit marks slot 0 of the frame. The left MSB follows in slot 1, and the right word follows the left LSB with no gap.
- R6: Word-length code 00 or 11 selects 24 bits, 01 selects 20 and 10 selects 16. The word is left-aligned in the 24-bit output and its unused low bits read zero.
- R7: Data-line values in slots outside the selected word window have no effect on any delivered sample.
- R8: Each delivered sample raises its channel's valid strobe for exactly one system cycle. The two strobes are never high together, and a channel's data output holds its value between that channel's strobes.
- R9: A channel's zero flag rises after ZERO_RUN consecutive all-zero samples on that channel and falls on that channel's first non-zero sample.
- R10: No sample is delivered before the first frame-clock transition (DSP: the first sync pulse) seen after reset. In particular, a partial right-justified half-frame at start-up is never reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial bit clock (asynchronous) |
| frame_i | input | 1 | Frame clock or DSP sync pulse (asynchronous) |
| sdata_i | input | 1 | Serial data, changed on the bit-clock fall |
| fmt_i | input | 2 | Framing select: 00 LJ, 01 I2S, 10 RJ, 11 DSP |
| wlen_i | input | 2 | Word length: 00/11 24 bits, 01 20, 10 16 |
| left_data_o | output | 24 | Last left sample, left-aligned |
| left_valid_o | output | 1 | One-cycle strobe on a new left sample |
| right_data_o | output | 24 | Last right sample, left-aligned |
| right_valid_o | output | 1 | One-cycle strobe on a new right sample |
| left_zero_o | output | 1 | Left channel silence flag |
| right_zero_o | output | 1 | Right channel silence flag |

## Verification
The assertions rely on each bit-clock phase lasting at least two system cycles. With that, every bit-clock rise becomes one single-cycle event after synchronisation, so a strobe can never be stretched or repeated. They also assume that the format and word-length codes change only while reset is held. The stimulus holds each bit-clock phase for three system cycles, pulses reset before every change of format or length, and moves the data and frame clock only while the bit clock is low. A scoreboard queue compares every strobe against the word the driver placed in its window. Pad slots carry ones in some frames, so any leak from outside the window shows up as a mismatch.

// File: rtl/sai_pkg.sv
// Shared codes for the serial audio input port.
package sai_pkg;
    typedef enum logic [1:0] {
        FMT_LJ  = 2'b00,
        FMT_I2S = 2'b01,
        FMT_RJ  = 2'b10,
        FMT_DSP = 2'b11
    } fmt_e;

    // Word length in bits for a word-length code (00 and 11 give 24)
    function automatic int unsigned word_bits(input logic [1:0] code);
        case (code)
            2'b01:   return 20;
            2'b10:   return 16;
            default: return 24;
        endcase
    endfunction
endpackage

// File: rtl/sai_sync.sv
// Multi-bit chain of flops that brings asynchronous single-bit signals into clk.
// Assumes each bit is independent and changes slowly compared with clk.
module sai_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    // Shift each input through STAGES flops
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d_i};
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sai_deser.sv
// Frame tracker and shifter: it finds the slot position from frame-clock edges
// and emits a left-aligned word plus its channel when the framing says it is done.
// Assumes synchronised inputs and bit-clock phases of at least two clk cycles.
module sai_deser import sai_pkg::*; #(
    parameter int SAMPLE_W    = 24,
    parameter int FRAME_SLOTS = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk_s,
    input  logic                fs_s,
    input  logic                sd_s,
    input  logic [1:0]          fmt_i,
    input  logic [1:0]          wlen_i,
    output logic [SAMPLE_W-1:0] word_o,
    output logic                vld_o,
    output logic                right_o
);
    localparam int              CNT_W    = $clog2(FRAME_SLOTS);
    localparam logic [CNT_W-1:0] SLOT_MAX = CNT_W'(FRAME_SLOTS - 1);

    fmt_e                fmt;
    logic                sclk_d, fs_last, primed, locked;
    logic                rise, edge_hit, emit, emit_right;
    logic [CNT_W-1:0]    cnt, cur_slot, wb;
    logic [SAMPLE_W-1:0] sr, sr_nx, emit_word;
    int unsigned         shift;

    assign fmt   = fmt_e'(fmt_i);
    assign wb    = CNT_W'(word_bits(wlen_i));
    assign shift = SAMPLE_W - word_bits(wlen_i);

    // Decode edges, slot position and the emit condition for this bit
    always_comb begin
        rise = sclk_s & ~sclk_d;
        if (fmt == FMT_DSP) edge_hit = primed & fs_s & ~fs_last;
        else                edge_hit = primed & (fs_s ^ fs_last);
        cur_slot   = edge_hit ? '0 : ((cnt == SLOT_MAX) ? cnt : cnt + 1'b1);
        sr_nx      = {sr[SAMPLE_W-2:0], sd_s};
        emit_word  = sr_nx << shift;
        emit       = 1'b0;
        emit_right = 1'b0;
        case (fmt)
            FMT_LJ: begin
                emit       = locked & (cur_slot == wb - 1'b1);
                emit_right = ~fs_s;
            end
            FMT_I2S: begin
                emit       = locked & (cur_slot == wb);
                emit_right = fs_s;
            end
            FMT_RJ: begin
                emit       = locked & edge_hit;
                emit_right = ~fs_last;
                emit_word  = sr << shift;
            end
            default: begin
                emit       = locked & ((cur_slot == wb) | (cur_slot == (wb << 1)));
                emit_right = (cur_slot == (wb << 1));
            end
        endcase
    end

    // Advance frame state on each bit-clock rise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d  <= 1'b0;
            fs_last <= 1'b0;
            primed  <= 1'b0;
            locked  <= 1'b0;
            cnt     <= SLOT_MAX;
            sr      <= '0;
        end else begin
            sclk_d <= sclk_s;
            if (rise) begin
                fs_last <= fs_s;
                primed  <= 1'b1;
                cnt     <= cur_slot;
                sr      <= sr_nx;
                if (edge_hit) locked <= 1'b1;
            end
        end
    end

    // Register the emitted word and its channel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o  <= '0;
            vld_o   <= 1'b0;
            right_o <= 1'b0;
        end else begin
            vld_o <= rise & emit;
            if (rise & emit) begin
                word_o  <= emit_word;
                right_o <= emit_right;
            end
        end
    end
endmodule

// File: rtl/sai_zero_det.sv
// Silence detector for one channel: counts consecutive zero samples.
// Assumes vld_i marks each new sample on data_i.
module sai_zero_det #(
    parameter int SAMPLE_W = 24,
    parameter int ZERO_RUN = 1024
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vld_i,
    input  logic [SAMPLE_W-1:0] data_i,
    output logic                zero_o
);
    localparam int             RUN_W    = $clog2(ZERO_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(ZERO_RUN - 1);
    localparam logic [RUN_W-1:0] RUN_TOP  = RUN_W'(ZERO_RUN);

    logic [RUN_W-1:0] run;

    // Count zero samples, saturate at the run length, clear on non-zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= '0;
            zero_o <= 1'b0;
        end else if (vld_i) begin
            if (data_i == '0) begin
                if (run != RUN_TOP) run <= run + 1'b1;
                zero_o <= zero_o | (run == RUN_LAST);
            end else begin
                run    <= '0;
                zero_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sai_rx_port.sv
// Multi-format serial audio input port. It synchronises the serial link,
// deserialises it and steers words into per-channel registers with silence flags.
// Assumes the format and length codes are static outside reset.
module sai_rx_port #(
    parameter int SAMPLE_W    = 24,
    parameter int FRAME_SLOTS = 64,
    parameter int ZERO_RUN    = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk_i,
    input  logic                frame_i,
    input  logic                sdata_i,
    input  logic [1:0]          fmt_i,
    input  logic [1:0]          wlen_i,
    output logic [SAMPLE_W-1:0] left_data_o,
    output logic                left_valid_o,
    output logic [SAMPLE_W-1:0] right_data_o,
    output logic                right_valid_o,
    output logic                left_zero_o,
    output logic                right_zero_o
);
    localparam int CHANNELS = 2;

    logic [2:0]          sync_q;
    logic [SAMPLE_W-1:0] w_word;
    logic                w_vld, w_right;
    logic [SAMPLE_W-1:0] ch_data [CHANNELS];
    logic                ch_vld  [CHANNELS];
    logic                ch_zero [CHANNELS];

    sai_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sclk_i, frame_i, sdata_i}),
        .q_o   (sync_q)
    );

    sai_deser #(.SAMPLE_W(SAMPLE_W), .FRAME_SLOTS(FRAME_SLOTS)) u_deser (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (sync_q[2]),
        .fs_s    (sync_q[1]),
        .sd_s    (sync_q[0]),
        .fmt_i   (fmt_i),
        .wlen_i  (wlen_i),
        .word_o  (w_word),
        .vld_o   (w_vld),
        .right_o (w_right)
    );

    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
        // Capture words addressed to this channel
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ch_data[ch] <= '0;
                ch_vld[ch]  <= 1'b0;
            end else begin
                ch_vld[ch] <= w_vld & (w_right == 1'(ch));
                if (w_vld & (w_right == 1'(ch))) ch_data[ch] <= w_word;
            end
        end

        sai_zero_det #(.SAMPLE_W(SAMPLE_W), .ZERO_RUN(ZERO_RUN)) u_zero (
            .clk    (clk),
            .rst_n  (rst_n),
            .vld_i  (ch_vld[ch]),
            .data_i (ch_data[ch]),
            .zero_o (ch_zero[ch])
        );
    end

    assign left_data_o   = ch_data[0];
    assign left_valid_o  = ch_vld[0];
    assign left_zero_o   = ch_zero[0];
    assign right_data_o  = ch_data[1];
    assign right_valid_o = ch_vld[1];
    assign right_zero_o  = ch_zero[1];
endmodule

// File: rtl/sai_rx_port_chk.sv
// Property checker for the serial audio input port, bound to every instance.
module sai_rx_port_chk #(
    parameter int SAMPLE_W = 24
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          wlen_i,
    input logic [SAMPLE_W-1:0] left_data_o,
    input logic                left_valid_o,
    input logic [SAMPLE_W-1:0] right_data_o,
    input logic                right_valid_o,
    input logic                left_zero_o,
    input logic                right_zero_o
);
    // R8
    left_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        left_valid_o |=> !left_valid_o);
    // R8
    right_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        right_valid_o |=> !right_valid_o);
    // R8
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(left_valid_o && right_valid_o));
    // R8
    left_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !left_valid_o |-> $stable(left_data_o));
    // R8
    right_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !right_valid_o |-> $stable(right_data_o));
    // R6
    short_word_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (left_valid_o && wlen_i == 2'b10) |-> left_data_o[SAMPLE_W-17:0] == '0);
    // R6
    mid_word_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (right_valid_o && wlen_i == 2'b01) |-> right_data_o[SAMPLE_W-21:0] == '0);
    // R9
    left_zero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (left_valid_o && left_data_o != '0) |=> !left_zero_o);
    // R9
    left_zero_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(left_zero_o) |-> ($past(left_valid_o) && $past(left_data_o) == '0));
    // R9
    right_zero_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(right_zero_o) |-> ($past(right_valid_o) && $past(right_data_o) == '0));
endmodule

bind sai_rx_port sai_rx_port_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wlen_i        (wlen_i),
    .left_data_o   (left_data_o),
    .left_valid_o  (left_valid_o),
    .right_data_o  (right_data_o),
    .right_valid_o (right_valid_o),
    .left_zero_o   (left_zero_o),
    .right_zero_o  (right_zero_o)
);

// File: tb/sai_rx_port_bench.sv
module sai_rx_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PHASE      = 3;
    localparam int ZRUN       = 8;

    typedef struct {
        bit          right;
        logic [23:0] data;
        int          req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, frame = 1'b0, sdata = 1'b0;
    logic [1:0]  fmt = 2'b00, wlen = 2'b00;
    logic [23:0] left_data, right_data;
    logic        left_valid, right_valid, left_zero, right_zero;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sai_rx_port #(.ZERO_RUN(ZRUN)) u_sai_rx_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .sclk_i        (sclk),
        .frame_i       (frame),
        .sdata_i       (sdata),
        .fmt_i         (fmt),
        .wlen_i        (wlen),
        .left_data_o   (left_data),
        .left_valid_o  (left_valid),
        .right_data_o  (right_data),
        .right_valid_o (right_valid),
        .left_zero_o   (left_zero),
        .right_zero_o  (right_zero)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic int wbits(input logic [1:0] code);
        if (code == 2'b01) return 20;
        if (code == 2'b10) return 16;
        return 24;
    endfunction

    // Monitor: pop the scoreboard on every strobe
    task automatic take(input bit r, input logic [23:0] d);
        exp_t e;
        n_checks++;
        if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R10 unexpected strobe ch=%0d actual=%h expected=none", r, d);
        end else begin
            e = exp_q.pop_front();
            if (e.right != r || e.data != d) begin
                n_fail++;
                $display("FAIL R%0d actual ch=%0d %h expected ch=%0d %h", e.req, r, d, e.right, e.data);
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (left_valid)  take(1'b0, left_data);
            if (right_valid) take(1'b1, right_data);
        end
    end

    task automatic bit_out(input logic fs, input logic d);
        @(negedge clk);
        sclk = 1'b0; frame = fs; sdata = d;
        repeat (PHASE - 1) @(negedge clk);
        @(negedge clk);
        sclk = 1'b1;
        repeat (PHASE - 1) @(negedge clk);
    endtask

    // Driver: push expectations, then serialise one frame
    task automatic send_frame(input logic [23:0] l, input logic [23:0] r, input logic pad, input int req);
        int          w = wbits(wlen);
        logic [31:0] mask = (32'h1 << w) - 1;
        logic [23:0] lw = 24'((32'(l) & mask) << (24 - w));
        logic [23:0] rw = 24'((32'(r) & mask) << (24 - w));
        exp_q.push_back('{right: 1'b0, data: lw, req: req});
        exp_q.push_back('{right: 1'b1, data: rw, req: req});
        for (int t = 0; t < 64; t++) begin
            int          h = t / 32;
            int          s = t % 32;
            logic [23:0] word = (h == 1) ? r : l;
            logic        fs, d;
            case (fmt)
                2'b00: begin fs = (h == 0); d = (s < w) ? word[w-1-s] : pad; end
                2'b01: begin fs = (h == 1); d = (s >= 1 && s <= w) ? word[w-s] : pad; end
                2'b10: begin fs = (h == 0); d = (s >= 32 - w) ? word[31-s] : pad; end
                default: begin
                    fs = (t == 0);
                    if (t >= 1 && t <= w)          d = l[w-t];
                    else if (t > w && t <= 2 * w)  d = r[2*w-t];
                    else                           d = pad;
                end
            endcase
            bit_out(fs, d);
        end
    endtask

    // Right-justified: one more frame-clock edge delivers the last right word
    task automatic flush_rj();
        for (int t = 0; t < 32; t++) bit_out(1'b1, 1'b1);
    endtask

    task automatic drain();
        int guard = 0;
        while (exp_q.size() != 0 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R8 missing strobe", 32'(exp_q.size()), 32'd0);
    endtask

    task automatic start(input logic [1:0] f, input logic [1:0] wl);
        @(negedge clk);
        rst_n = 1'b0; fmt = f; wlen = wl;
        sclk = 1'b0; sdata = 1'b0; frame = (f == 2'b01);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) bit_out(frame, 1'b1);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(left_data == 0,  "R1 left data",  32'(left_data), 0);
        check(right_data == 0, "R1 right data", 32'(right_data), 0);
        check(!left_valid && !right_valid, "R1 strobes", {left_valid, right_valid}, 0);
        check(!left_zero && !right_zero, "R1 zero flags", {left_zero, right_zero}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(left_data == 0 && !left_valid && !right_valid, "R1 after release", 32'(left_data), 0);

        // R2, R6, R7: left-justified, 24 and 16 bits, pad slots driven high
        start(2'b00, 2'b00);
        send_frame(24'h7A5C31, 24'h81F0E2, 1'b0, 2);
        send_frame(24'h123456, 24'hFEDCBA, 1'b1, 7);
        drain();
        start(2'b00, 2'b10);
        send_frame(24'h00C3A5, 24'h008001, 1'b1, 6);
        drain();

        // R3: I2S, 20 and 24 bits
        start(2'b01, 2'b01);
        send_frame(24'h0ABCDE, 24'h080001, 1'b1, 3);
        send_frame(24'h055AA5, 24'h0FFFFF, 1'b0, 3);
        drain();
        start(2'b01, 2'b00);
        send_frame(24'hC0FFEE, 24'h000001, 1'b1, 3);
        drain();

        // R4, R10: right-justified, start-up half ignored, pad slots high
        start(2'b10, 2'b00);
        send_frame(24'h9E3779, 24'h3C6EF3, 1'b1, 4);
        send_frame(24'h000100, 24'hFFFFFF, 1'b1, 10);
        flush_rj();
        drain();
        start(2'b10, 2'b10);
        send_frame(24'h00ABCD, 24'h007FFF, 1'b1, 4);
        flush_rj();
        drain();
        start(2'b10, 2'b01);
        send_frame(24'h0F00F1, 24'h0800A0, 1'b1, 4);
        flush_rj();
        drain();

        // R5: DSP word sync, 24, 16 and reserved code 11 as 24
        start(2'b11, 2'b00);
        send_frame(24'h5A5A5A, 24'hA1B2C3, 1'b1, 5);
        send_frame(24'h800000, 24'h7FFFFF, 1'b0, 5);
        drain();
        start(2'b11, 2'b10);
        send_frame(24'h00BEEF, 24'h001234, 1'b1, 5);
        drain();
        start(2'b11, 2'b11);
        send_frame(24'h13579B, 24'h2468AC, 1'b1, 6);
        drain();

        // R9: silence flag after ZRUN zero samples, cleared by a non-zero one
        start(2'b00, 2'b00);
        for (int i = 0; i < ZRUN - 1; i++) send_frame(24'h0, 24'h000123, 1'b0, 9);
        drain();
        check(!left_zero, "R9 early left flag", 32'(left_zero), 0);
        send_frame(24'h0, 24'h000123, 1'b0, 9);
        drain();
        check(left_zero, "R9 left flag set", 32'(left_zero), 1);
        check(!right_zero, "R9 right flag stays low", 32'(right_zero), 0);
        send_frame(24'h000001, 24'h0, 1'b0, 9);
        drain();
        check(!left_zero, "R9 left flag cleared", 32'(left_zero), 0);

        finish_run();
    end
endmodule